// File: doc/BRIEF.md
# Bitwise Logic Execution Unit with Test Flag

This unit is the logical slice of a 32-bit integer pipeline. Each cycle it may accept one operation, given as an opcode, two register values, an 8-bit immediate and a valid strobe. It computes AND, OR, XOR or NOT, or a bit test whose only effect is the single-bit T flag. One clock later it presents a registered result with its write strobes. The register file reads the operands and takes the results. The unit itself holds no architectural registers.

Operand `in_rn` carries the value of the destination register. For the immediate forms, the register file must present register 0 on `in_rn`, because those forms always read and write register 0. The immediate is padded with zeros for AND, OR and XOR. For the bit test it is padded with copies of its top bit. Opcodes that have no defined function are flagged as illegal and change no state. This covers the combined forms that merge a negation with AND or OR.

Top module: `logic_unit`

## Requirements
- R1: Opcodes 0, 1 and 2 (register AND, OR, XOR) produce `in_rn & in_rm`, `in_rn | in_rm` and `in_rn ^ in_rm` respectively, with `out_wr_en`=1 and `out_wr_r0`=0.
- R2: Opcode 3 (NOT) produces the bitwise complement of `in_rm` with `out_wr_en`=1, and the value of `in_rn` has no effect on it.
- R3: Opcodes 5, 6 and 7 (immediate AND, OR, XOR) combine `in_rn` with the immediate zero-extended to 32 bits, and assert both `out_wr_en` and `out_wr_r0`.
- R4: Opcode 4 (register test) asserts `out_t_we` with `out_t_val`=1 exactly when `in_rn & in_rm` is zero, and does not assert `out_wr_en`.
- R5: Opcode 8 (immediate test) ANDs `in_rn` with the immediate sign-extended to 32 bits, sets `out_t_val`=1 exactly when that is zero, asserts `out_t_we` and does not assert `out_wr_en`.
- R6: Opcodes 0 to 3 and 5 to 7 never assert `out_t_we`, and `out_t_val` keeps its last value whenever no test completes.
- R7: Opcodes 9 to 15 assert `out_illegal` for one cycle and assert neither `out_wr_en` nor `out_t_we`.
- R8: All strobes appear in the cycle after the accepting edge. A cycle without `in_valid` produces no strobe on the following cycle.
- R9: `out_result` keeps its previous value in every cycle where `out_wr_en` is low.
- R10: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 4 | Operation code (see requirements) |
| in_rn | input | 32 | Destination register value (register 0 for immediate forms) |
| in_rm | input | 32 | Source register value |
| in_imm | input | 8 | Immediate field |
| out_wr_en | output | 1 | Write `out_result` to the destination register |
| out_wr_r0 | output | 1 | The destination is register 0 (immediate forms) |
| out_result | output | 32 | Registered result value |
| out_t_we | output | 1 | Update the T flag |
| out_t_val | output | 1 | New T flag value |
| out_illegal | output | 1 | The accepted opcode was illegal |

## Verification
On every cycle the assertions check several properties. Strobes are mutually exclusive. Idle and illegal cycles stay quiet. The result is held while no write occurs. The NOT, register-test and immediate-AND results match their operands one cycle later. Only the bench scenarios exercise the sign- versus zero-extension split with immediates that have bit 7 set. They also cover the held T value across mixed sequences, the reset state, and back-to-back issue with idle gaps in between.

// File: rtl/logic_unit_pkg.sv
// Package: shared opcode encoding and decoded-control type for the logic unit.
// Assumes a 4-bit opcode; codes above OPC_TST_I are undefined.
package logic_unit_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OPC_AND_R = 4'd0,
        OPC_OR_R  = 4'd1,
        OPC_XOR_R = 4'd2,
        OPC_NOT_R = 4'd3,
        OPC_TST_R = 4'd4,
        OPC_AND_I = 4'd5,
        OPC_OR_I  = 4'd6,
        OPC_XOR_I = 4'd7,
        OPC_TST_I = 4'd8
    } opcode_e;

    typedef enum logic [1:0] {
        FN_AND = 2'd0,
        FN_OR  = 2'd1,
        FN_XOR = 2'd2,
        FN_NOT = 2'd3
    } bit_fn_e;

    typedef struct packed {
        logic    legal;      // opcode has a defined function
        logic    use_imm;    // second operand is the immediate, destination is r0
        logic    imm_sext;   // immediate is sign-extended instead of zero-extended
        logic    writes_reg; // result goes to a general register
        logic    writes_t;   // zero test goes to the T flag
        bit_fn_e fn;         // bitwise function applied
    } lu_ctrl_t;

endpackage

// File: rtl/lu_decode.sv
// Module: lu_decode
// Turns the raw opcode into control flags. Purely combinational.
// Assumes undefined codes leave every flag low.
module lu_decode
    import logic_unit_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output lu_ctrl_t        ctrl_o
);

    // Map each defined opcode to its control flags.
    always_comb begin
        ctrl_o    = '0;
        ctrl_o.fn = FN_AND;
        case (op_i)
            OPC_AND_R: begin ctrl_o.legal = 1'b1; ctrl_o.writes_reg = 1'b1; ctrl_o.fn = FN_AND; end
            OPC_OR_R:  begin ctrl_o.legal = 1'b1; ctrl_o.writes_reg = 1'b1; ctrl_o.fn = FN_OR;  end
            OPC_XOR_R: begin ctrl_o.legal = 1'b1; ctrl_o.writes_reg = 1'b1; ctrl_o.fn = FN_XOR; end
            OPC_NOT_R: begin ctrl_o.legal = 1'b1; ctrl_o.writes_reg = 1'b1; ctrl_o.fn = FN_NOT; end
            OPC_TST_R: begin ctrl_o.legal = 1'b1; ctrl_o.writes_t   = 1'b1; ctrl_o.fn = FN_AND; end
            OPC_AND_I: begin
                ctrl_o.legal = 1'b1; ctrl_o.writes_reg = 1'b1; ctrl_o.use_imm = 1'b1; ctrl_o.fn = FN_AND;
            end
            OPC_OR_I: begin
                ctrl_o.legal = 1'b1; ctrl_o.writes_reg = 1'b1; ctrl_o.use_imm = 1'b1; ctrl_o.fn = FN_OR;
            end
            OPC_XOR_I: begin
                ctrl_o.legal = 1'b1; ctrl_o.writes_reg = 1'b1; ctrl_o.use_imm = 1'b1; ctrl_o.fn = FN_XOR;
            end
            OPC_TST_I: begin
                ctrl_o.legal = 1'b1; ctrl_o.writes_t = 1'b1; ctrl_o.use_imm = 1'b1;
                ctrl_o.imm_sext = 1'b1; ctrl_o.fn = FN_AND;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/lu_operand.sv
// Module: lu_operand
// Chooses the second operand: the source register, or the immediate
// widened to DATA_W with zero or sign fill. Assumes IMM_W < DATA_W.
module lu_operand #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8
) (
    input  logic [DATA_W-1:0] rm_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              use_imm_i,
    input  logic              sext_i,
    output logic [DATA_W-1:0] opb_o
);

    localparam int FILL_W = DATA_W - IMM_W;

    logic              fill_bit;
    logic [DATA_W-1:0] imm_wide;

    // Widen the immediate with the selected fill.
    always_comb begin
        fill_bit = sext_i & imm_i[IMM_W-1];
        imm_wide = {{FILL_W{fill_bit}}, imm_i};
    end

    // Select register or immediate as the second operand.
    always_comb begin
        opb_o = use_imm_i ? imm_wide : rm_i;
    end

endmodule

// File: rtl/lu_bitops.sv
// Module: lu_bitops
// Applies the bitwise function and flags an all-zero AND result.
// The zero detect is split into CHUNK_W lanes whose flags are then combined.
// Assumes DATA_W is a multiple of CHUNK_W.
module lu_bitops
    import logic_unit_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CHUNK_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  bit_fn_e           fn_i,
    output logic [DATA_W-1:0] res_o,
    output logic              and_zero_o
);

    localparam int N_CHUNK = DATA_W / CHUNK_W;

    logic [DATA_W-1:0]  and_v;
    logic [N_CHUNK-1:0] lane_nz;

    assign and_v = a_i & b_i;

    // Per-lane nonzero flags for the test result.
    for (genvar g = 0; g < N_CHUNK; g++) begin : g_lane
        assign lane_nz[g] = |and_v[g*CHUNK_W +: CHUNK_W];
    end

    // Combine the lane flags into one zero indication.
    always_comb begin
        and_zero_o = ~(|lane_nz);
    end

    // Apply the selected bitwise function.
    always_comb begin
        case (fn_i)
            FN_AND:  res_o = and_v;
            FN_OR:   res_o = a_i | b_i;
            FN_XOR:  res_o = a_i ^ b_i;
            default: res_o = ~b_i;
        endcase
    end

endmodule

// File: rtl/logic_unit.sv
// Module: logic_unit (top)
// Bitwise logic execution unit with a T-flag test. An operation accepted on
// in_valid is decoded, its operand is selected and its result computed in
// one cycle. Results and strobes are registered and appear on the following
// cycle. Assumes the caller drives register 0 on in_rn for immediate forms.
module logic_unit
    import logic_unit_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 8,
    parameter int CHUNK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic [DATA_W-1:0] in_rn,
    input  logic [DATA_W-1:0] in_rm,
    input  logic [IMM_W-1:0]  in_imm,
    output logic              out_wr_en,
    output logic              out_wr_r0,
    output logic [DATA_W-1:0] out_result,
    output logic              out_t_we,
    output logic              out_t_val,
    output logic              out_illegal
);

    lu_ctrl_t          ctrl;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] res;
    logic              and_zero;
    logic              take_reg;
    logic              take_t;
    logic              take_bad;

    lu_decode u_decode (
        .op_i   (in_op),
        .ctrl_o (ctrl)
    );

    lu_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_operand (
        .rm_i      (in_rm),
        .imm_i     (in_imm),
        .use_imm_i (ctrl.use_imm),
        .sext_i    (ctrl.imm_sext),
        .opb_o     (opb)
    );

    lu_bitops #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W)) u_bitops (
        .a_i        (in_rn),
        .b_i        (opb),
        .fn_i       (ctrl.fn),
        .res_o      (res),
        .and_zero_o (and_zero)
    );

    // Qualify the decoded effects with the valid strobe.
    always_comb begin
        take_reg = in_valid & ctrl.legal & ctrl.writes_reg;
        take_t   = in_valid & ctrl.legal & ctrl.writes_t;
        take_bad = in_valid & ~ctrl.legal;
    end

    // Register strobes, result and T value for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_wr_en   <= 1'b0;
            out_wr_r0   <= 1'b0;
            out_result  <= '0;
            out_t_we    <= 1'b0;
            out_t_val   <= 1'b0;
            out_illegal <= 1'b0;
        end else begin
            out_wr_en   <= take_reg;
            out_wr_r0   <= take_reg & ctrl.use_imm;
            out_t_we    <= take_t;
            out_illegal <= take_bad;
            if (take_reg) begin
                out_result <= res;
            end
            if (take_t) begin
                out_t_val <= and_zero;
            end
        end
    end

endmodule

// File: rtl/logic_unit_chk.sv
// Module: logic_unit_chk
// Cycle-by-cycle properties of logic_unit, attached with bind below.
// Watches ports only; assumes reset is held for at least one clock.
module logic_unit_chk
    import logic_unit_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OP_W-1:0]   in_op,
    input logic [DATA_W-1:0] in_rn,
    input logic [DATA_W-1:0] in_rm,
    input logic [IMM_W-1:0]  in_imm,
    input logic              out_wr_en,
    input logic              out_wr_r0,
    input logic [DATA_W-1:0] out_result,
    input logic              out_t_we,
    input logic              out_t_val,
    input logic              out_illegal
);

    localparam int ZEXT_W = DATA_W - IMM_W;

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_wr_en && !out_t_we && !out_illegal));

    // R7
    illegal_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op > OPC_TST_I) |=> (out_illegal && !out_wr_en && !out_t_we));

    // R2
    not_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OPC_NOT_R) |=> (out_wr_en && out_result == ~$past(in_rm)));

    // R4
    tst_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OPC_TST_R) |=>
            (out_t_we && !out_wr_en && (out_t_val == (($past(in_rn) & $past(in_rm)) == '0))));

    // R3
    and_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OPC_AND_I) |=>
            (out_wr_en && out_wr_r0 &&
             out_result == ($past(in_rn) & {{ZEXT_W{1'b0}}, $past(in_imm)})));

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_wr_en, out_t_we, out_illegal}));

    // R3
    r0_implies_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr_r0 |-> out_wr_en);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_wr_en |-> $stable(out_result));

endmodule

bind logic_unit logic_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_op       (in_op),
    .in_rn       (in_rn),
    .in_rm       (in_rm),
    .in_imm      (in_imm),
    .out_wr_en   (out_wr_en),
    .out_wr_r0   (out_wr_r0),
    .out_result  (out_result),
    .out_t_we    (out_t_we),
    .out_t_val   (out_t_val),
    .out_illegal (out_illegal)
);

// File: tb/logic_unit_tb_top.sv
// Scoreboard bench for logic_unit: the driver pushes one expected item per
// cycle, and the monitor pops and compares it after the next rising edge.
module logic_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [3:0]  in_op;
    logic [31:0] in_rn;
    logic [31:0] in_rm;
    logic [7:0]  in_imm;
    logic        out_wr_en;
    logic        out_wr_r0;
    logic [31:0] out_result;
    logic        out_t_we;
    logic        out_t_val;
    logic        out_illegal;

    typedef struct {
        logic        wr;
        logic        wr_r0;
        logic        twe;
        logic        tval;
        logic        ill;
        logic [31:0] res;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          total = 0;
    int          bad   = 0;
    logic [31:0] mdl_res = '0;
    logic        mdl_t   = 1'b0;
    bit          mon_on  = 1'b0;
    bit          done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    logic_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_op       (in_op),
        .in_rn       (in_rn),
        .in_rm       (in_rm),
        .in_imm      (in_imm),
        .out_wr_en   (out_wr_en),
        .out_wr_r0   (out_wr_r0),
        .out_result  (out_result),
        .out_t_we    (out_t_we),
        .out_t_val   (out_t_val),
        .out_illegal (out_illegal)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive one cycle of stimulus and push the expected outcome.
    task automatic drive(input logic v, input logic [3:0] op, input logic [31:0] rn,
                         input logic [31:0] rm, input logic [7:0] imm, input string tag);
        exp_t        e;
        logic [31:0] zx;
        logic [31:0] sx;
        logic [31:0] r;
        @(negedge clk);
        in_valid = v; in_op = op; in_rn = rn; in_rm = rm; in_imm = imm;
        zx = {24'h0, imm};
        sx = {{24{imm[7]}}, imm};
        r  = '0;
        case (op)
            4'd0: r = rn & rm;
            4'd1: r = rn | rm;
            4'd2: r = rn ^ rm;
            4'd3: r = ~rm;
            4'd5: r = rn & zx;
            4'd6: r = rn | zx;
            4'd7: r = rn ^ zx;
            default: r = '0;
        endcase
        e.wr    = v && (op <= 4'd3 || (op >= 4'd5 && op <= 4'd7));
        e.wr_r0 = v && op >= 4'd5 && op <= 4'd7;
        e.twe   = v && (op == 4'd4 || op == 4'd8);
        e.ill   = v && op > 4'd8;
        if (e.wr) mdl_res = r;
        if (v && op == 4'd4) mdl_t = ((rn & rm) == 32'h0);
        if (v && op == 4'd8) mdl_t = ((rn & sx) == 32'h0);
        e.res  = mdl_res;
        e.tval = mdl_t;
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare outputs against the scoreboard just after each edge.
    always @(posedge clk) begin
        #1;
        if (mon_on && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.tag, "wr_en",   {31'h0, out_wr_en},   {31'h0, e.wr});
            check(e.tag, "wr_r0",   {31'h0, out_wr_r0},   {31'h0, e.wr_r0});
            check(e.tag, "t_we",    {31'h0, out_t_we},    {31'h0, e.twe});
            check(e.tag, "t_val",   {31'h0, out_t_val},   {31'h0, e.tval});
            check(e.tag, "illegal", {31'h0, out_illegal}, {31'h0, e.ill});
            check(e.tag, "result",  out_result,           e.res);
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_rn = '0; in_rm = '0; in_imm = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        check("R10", "wr_en",   {31'h0, out_wr_en},   32'h0);
        check("R10", "t_we",    {31'h0, out_t_we},    32'h0);
        check("R10", "t_val",   {31'h0, out_t_val},   32'h0);
        check("R10", "illegal", {31'h0, out_illegal}, 32'h0);
        check("R10", "result",  out_result,           32'h0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R1: register forms with several patterns
        drive(1, 4'd0, 32'hF0F0_1234, 32'h0FF0_FF00, 8'h00, "R1");
        drive(1, 4'd1, 32'hF0F0_1234, 32'h0FF0_FF00, 8'h00, "R1");
        drive(1, 4'd2, 32'hAAAA_5555, 32'hFFFF_0000, 8'h00, "R1");
        drive(1, 4'd2, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 8'h00, "R1");
        // R2: NOT ignores rn
        drive(1, 4'd3, 32'h0000_0000, 32'h1234_5678, 8'h00, "R2");
        drive(1, 4'd3, 32'hFFFF_FFFF, 32'h1234_5678, 8'h00, "R2");
        // R3: immediate forms zero-extend, target r0
        drive(1, 4'd5, 32'hFFFF_FFFF, 32'h0000_0000, 8'h80, "R3");
        drive(1, 4'd6, 32'h1200_0000, 32'hFFFF_FFFF, 8'hA5, "R3");
        drive(1, 4'd7, 32'hFFFF_FF00, 32'h0000_0000, 8'hFF, "R3");
        // R4: register test, zero and nonzero
        drive(1, 4'd4, 32'hF000_0000, 32'h0FFF_FFFF, 8'h00, "R4");
        drive(1, 4'd4, 32'h0001_0000, 32'h0001_0000, 8'h00, "R4");
        // R5: immediate test sign-extends (0x80 reaches bit 31)
        drive(1, 4'd8, 32'h8000_0000, 32'h0000_0000, 8'h80, "R5");
        drive(1, 4'd8, 32'h8000_0000, 32'h0000_0000, 8'h7F, "R5");
        drive(1, 4'd8, 32'h0000_0001, 32'h0000_0000, 8'h01, "R5");
        // R6: T held across non-test ops
        drive(1, 4'd1, 32'h0000_0000, 32'h0000_0000, 8'h00, "R6");
        drive(1, 4'd6, 32'h0000_0000, 32'h0000_0000, 8'h00, "R6");
        drive(1, 4'd3, 32'h0000_0000, 32'hFFFF_FFFF, 8'h00, "R6");
        // R7: every illegal opcode, result and T held
        for (int k = 9; k < 16; k++) begin
            drive(1, 4'(k), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'hFF, "R7");
        end
        // R8 R9: idle cycles with busy inputs produce nothing
        drive(0, 4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'h00, "R8 R9");
        drive(0, 4'd4, 32'h0000_0000, 32'h0000_0000, 8'h00, "R8 R9");
        drive(1, 4'd2, 32'h0F0F_0F0F, 32'hFFFF_FFFF, 8'h00, "R8");
        drive(0, 4'd3, 32'h0000_0000, 32'h0000_0000, 8'h00, "R8 R9");
        drive(1, 4'd8, 32'h0000_0100, 32'h0000_0000, 8'hFE, "R5");
        drive(0, 4'd0, 32'h0, 32'h0, 8'h00, "R8 R9");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule